// File: doc/BRIEF.md
# Configurable Quadrature Encoder Counter

This block turns the two signal lines of an incremental encoder into a 16-bit position count. It can decode the lines as a pair of phase-shifted quadrature channels. It can also treat them as a direction level plus a count clock. The resolution is either single-edge or both-edge, and the sense of channel 1 can be flipped to reverse the counting direction. Both raw inputs are resynchronised to the system clock before any edge is detected.

A small control machine has three states: stopped, ready and active. A start command loads the mode, resolution and inversion inputs. Enable lets the counter run. Disable freezes it. Stop parks the block. There are two readouts. The count strobe captures the current position. The delta strobe returns the signed movement since the previous delta read and remembers the new position for the next one.

Top module: `qenc_counter`

## Requirements
- R1: In quadrature mode with both-edge resolution, every single-channel transition moves the count by one. The channels are encoded as phase sequence 00, 10, 11, 01 for (ch1, ch2). Stepping forward through that sequence counts up and stepping backward counts down.
- R2: With single-edge resolution (`cfg_both`=0), quadrature mode counts only transitions of channel 1, so one full phase cycle moves the count by 2 instead of 4.
- R3: In direction/clock mode (`cfg_dirclk`=1), channel 2 is the clock and channel 1 the direction. Rising clock edges count in single-edge resolution, and both clock edges count in both-edge resolution. A direction level of 0 counts up and 1 counts down.
- R4: With `cfg_inv`=1, channel 1 is inverted before decoding, which reverses the counting direction in both modes.
- R5: The count is 16 bits and wraps from 0xFFFF to 0 going up and from 0 to 0xFFFF going down. It changes by at most one per cycle.
- R6: `state_o` encodes stopped=0, ready=1, active=2 and resets to stopped. Start from stopped or ready gives ready. Enable from ready gives active. Disable from ready or active gives ready. Stop from stopped or ready gives stopped. Any other command is ignored. When several commands arrive together, start wins, then stop, then enable, then disable.
- R7: The count moves only while active, and disable keeps its value. A start from stopped clears both the count and the stored last count to 0.
- R8: A delta read in ready or active returns (count − last count) modulo 2^16 as a two's-complement value, then stores the count as the new last count.
- R9: A delta read in the stopped state returns 0 and pulses `rd_err` high for one cycle.
- R10: In quadrature mode, a cycle in which both channels change is not counted and sets the sticky `seq_err`. Only an accepted start clears it.
- R11: The mode, resolution and inversion inputs are used only when a start is accepted. A start while active is ignored.
- R12: Each channel passes two synchroniser stages, so a change driven before clock edge k shows in the count after edge k+2. `count_o` and `delta_o` are registered: they update in the cycle after their strobe, hold otherwise, and include a step that happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch1_i | input | 1 | Encoder channel 1 (phase A or direction) |
| ch2_i | input | 1 | Encoder channel 2 (phase B or count clock) |
| cfg_dirclk | input | 1 | 1 selects direction/clock mode, 0 quadrature |
| cfg_both | input | 1 | 1 selects both-edge resolution |
| cfg_inv | input | 1 | 1 inverts channel 1 |
| cmd_start | input | 1 | Start strobe (loads configuration) |
| cmd_stop | input | 1 | Stop strobe |
| cmd_enable | input | 1 | Enable strobe |
| cmd_disable | input | 1 | Disable strobe |
| rd_count | input | 1 | Count read strobe |
| rd_delta | input | 1 | Delta read strobe |
| count_o | output | 16 | Registered position count |
| delta_o | output | 16 | Registered signed delta |
| rd_err | output | 1 | Illegal delta read pulse |
| seq_err | output | 1 | Sticky illegal quadrature step |
| state_o | output | 2 | Control state |

## Verification
The quadrature channels are driven with forward and reverse phase walks in every combination of resolution and inversion. Comparing the resulting count against a phase-difference model separates the direction sense from the resolution, and single-edge from both-edge counting. In direction/clock mode, clock toggles are applied under both direction levels. Further patterns cover a double-channel jump, which must be rejected, steps across zero in both directions to check wrap and signed delta, and configuration changes and commands issued in the wrong state, which must leave the count and state untouched.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    ST_STOPPED = 2'd0,
    ST_READY   = 2'd1,
    ST_ACTIVE  = 2'd2
  } qenc_state_e;

  typedef struct packed {
    logic dirclk;
    logic both;
    logic inv;
  } qenc_cfg_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] ch_s,
  input  qenc_cfg_t cfg,
  output logic      step_up,
  output logic      step_dn,
  output logic      step_bad
);
  logic [1:0] prev_q;
  logic a_n, b_n, a_o, b_o, edge_a, edge_b, clk_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= ch_s;
  end

  // inversion is applied to both samples so a new setting never fakes an edge
  assign a_n    = ch_s[0] ^ cfg.inv;
  assign b_n    = ch_s[1];
  assign a_o    = prev_q[0] ^ cfg.inv;
  assign b_o    = prev_q[1];
  assign edge_a = a_n ^ a_o;
  assign edge_b = b_n ^ b_o;
  assign clk_ev = (b_n & ~b_o) | (cfg.both & ~b_n & b_o);

  always_comb begin
    step_up  = 1'b0;
    step_dn  = 1'b0;
    step_bad = 1'b0;
    if (cfg.dirclk) begin
      step_up = clk_ev & ~a_n;
      step_dn = clk_ev & a_n;
    end else if (edge_a && edge_b) begin
      step_bad = 1'b1;
    end else if (edge_a) begin
      step_up = (a_n != b_n);
      step_dn = (a_n == b_n);
    end else if (edge_b && cfg.both) begin
      step_up = (a_n == b_n);
      step_dn = (a_n != b_n);
    end
  end
endmodule

// File: rtl/qenc_ctl.sv
module qenc_ctl
  import qenc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_stop,
  input  logic        cmd_enable,
  input  logic        cmd_disable,
  input  qenc_cfg_t   cfg_in,
  output qenc_state_e state,
  output qenc_cfg_t   cfg,
  output logic        start_ok,
  output logic        clr
);
  qenc_state_e state_q, state_d;
  qenc_cfg_t   cfg_q, cfg_d;

  assign start_ok = cmd_start && (state_q != ST_ACTIVE);
  assign clr      = cmd_start && (state_q == ST_STOPPED);

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    if (start_ok) begin
      state_d = ST_READY;
      cfg_d   = cfg_in;
    end else if (cmd_stop && state_q != ST_ACTIVE) begin
      state_d = ST_STOPPED;
    end else if (cmd_enable && state_q == ST_READY) begin
      state_d = ST_ACTIVE;
    end else if (cmd_disable && state_q != ST_STOPPED) begin
      state_d = ST_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STOPPED;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
    end
  end

  assign state = state_q;
  assign cfg   = cfg_q;
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic             cfg_dirclk,
  input  logic             cfg_both,
  input  logic             cfg_inv,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_enable,
  input  logic             cmd_disable,
  input  logic             rd_count,
  input  logic             rd_delta,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] delta_o,
  output logic             rd_err,
  output logic             seq_err,
  output logic [1:0]       state_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [1:0]  ch_s;
  qenc_cfg_t   cfg_in, cfg;
  qenc_state_e state;
  logic        start_ok, clr, step_up, step_dn, step_bad, active, legal_rd;

  logic [CNT_W-1:0] cnt_q, cnt_d, last_q, last_d, count_d, delta_d;
  logic             rd_err_d, seq_err_q, seq_err_d;

  assign cfg_in = '{dirclk: cfg_dirclk, both: cfg_both, inv: cfg_inv};

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d_i ({ch2_i, ch1_i}), .q_o (ch_s)
  );

  qenc_decode u_dec (
    .clk (clk), .rst_n (rst_n), .ch_s (ch_s), .cfg (cfg),
    .step_up (step_up), .step_dn (step_dn), .step_bad (step_bad)
  );

  qenc_ctl u_ctl (
    .clk (clk), .rst_n (rst_n),
    .cmd_start (cmd_start), .cmd_stop (cmd_stop),
    .cmd_enable (cmd_enable), .cmd_disable (cmd_disable),
    .cfg_in (cfg_in), .state (state), .cfg (cfg),
    .start_ok (start_ok), .clr (clr)
  );

  assign active   = (state == ST_ACTIVE);
  assign legal_rd = (state == ST_READY) || (state == ST_ACTIVE);

  always_comb begin
    if (clr)                  cnt_d = '0;
    else if (active && step_up) cnt_d = cnt_q + CNT_ONE;
    else if (active && step_dn) cnt_d = cnt_q - CNT_ONE;
    else                      cnt_d = cnt_q;

    last_d   = last_q;
    delta_d  = delta_o;
    rd_err_d = 1'b0;
    if (clr) begin
      last_d = '0;
    end
    if (rd_delta) begin
      if (legal_rd) begin
        delta_d = cnt_d - last_q;
        last_d  = cnt_d;
      end else begin
        delta_d  = '0;
        rd_err_d = 1'b1;
      end
    end

    count_d   = rd_count ? cnt_d : count_o;
    seq_err_d = start_ok ? 1'b0 : (seq_err_q | (active & step_bad));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      last_q    <= '0;
      count_o   <= '0;
      delta_o   <= '0;
      rd_err    <= 1'b0;
      seq_err_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      last_q    <= last_d;
      count_o   <= count_d;
      delta_o   <= delta_d;
      rd_err    <= rd_err_d;
      seq_err_q <= seq_err_d;
    end
  end

  assign seq_err = seq_err_q;
  assign state_o = state;
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             cmd_enable,
  input logic             rd_delta,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] delta_o,
  input logic             rd_err,
  input logic             seq_err
);
  assert_state_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);

  assert_enable_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_enable && !cmd_start && !cmd_stop && state_o == 2'd0) |=> state_o == 2'd0);

  assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd2 && !cmd_start) |=> $stable(cnt_q));

  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 ||
                    cnt_q == $past(cnt_q) - 1'b1));

  assert_bad_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_delta && state_o == 2'd0) |=> (rd_err && delta_o == '0));

  assert_seq_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !cmd_start) |=> seq_err);
endmodule

bind qenc_counter qenc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_stop (cmd_stop),
  .cmd_enable (cmd_enable), .rd_delta (rd_delta), .state_o (state_o),
  .cnt_q (cnt_q), .delta_o (delta_o), .rd_err (rd_err), .seq_err (seq_err)
);

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;
  logic clk = 1'b0;
  logic rst_n;
  logic ch1, ch2, cfg_dirclk, cfg_both, cfg_inv;
  logic cmd_start, cmd_stop, cmd_enable, cmd_disable, rd_count, rd_delta;
  logic [15:0] count_o, delta_o;
  logic rd_err, seq_err;
  logic [1:0] state_o;

  always #4 clk = ~clk;

  qenc_counter u0 (
    .clk (clk), .rst_n (rst_n), .ch1_i (ch1), .ch2_i (ch2),
    .cfg_dirclk (cfg_dirclk), .cfg_both (cfg_both), .cfg_inv (cfg_inv),
    .cmd_start (cmd_start), .cmd_stop (cmd_stop), .cmd_enable (cmd_enable),
    .cmd_disable (cmd_disable), .rd_count (rd_count), .rd_delta (rd_delta),
    .count_o (count_o), .delta_o (delta_o), .rd_err (rd_err),
    .seq_err (seq_err), .state_o (state_o)
  );

  int n_vec = 0;
  int n_fail = 0;
  bit finished = 0;
  int ph = 0;

  task automatic chk(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state, m_cnt, m_last, m_count, m_delta;
  bit m_rderr, m_seqerr, m_dirclk, m_both, m_inv;
  bit [1:0] m_h [$];

  function automatic int phase_of(bit a, bit b);
    if (a) return b ? 2 : 1;
    return b ? 3 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_last = 0; m_count = 0; m_delta = 0;
      m_rderr = 0; m_seqerr = 0; m_dirclk = 0; m_both = 0; m_inv = 0;
      m_h = '{2'b00, 2'b00, 2'b00};
    end else begin
      bit a_n, b_n, a_o, b_o, bad, clr, st_ok;
      int step, d, newcnt;
      // m_h[0] oldest (decoder reference), m_h[1] newest synchronised sample
      a_n = m_h[1][0] ^ m_inv; b_n = m_h[1][1];
      a_o = m_h[0][0] ^ m_inv; b_o = m_h[0][1];
      step = 0; bad = 0;
      if (!m_dirclk) begin
        d = (phase_of(a_n, b_n) - phase_of(a_o, b_o) + 4) % 4;
        if (d == 2) bad = 1;
        else if (d != 0 && (m_both || a_n != a_o)) step = (d == 1) ? 1 : -1;
      end else if ((b_n && !b_o) || (m_both && !b_n && b_o)) begin
        step = a_n ? -1 : 1;
      end
      clr   = cmd_start && m_state == 0;
      st_ok = cmd_start && m_state != 2;
      newcnt = clr ? 0 : (m_state == 2) ? ((m_cnt + step) & 16'hFFFF) : m_cnt;
      if (clr) m_last = 0;
      m_rderr = 0;
      if (rd_delta) begin
        if (m_state != 0) begin
          m_delta = (newcnt - m_last) & 16'hFFFF;
          m_last = newcnt;
        end else begin
          m_delta = 0; m_rderr = 1;
        end
      end
      if (rd_count) m_count = newcnt;
      m_seqerr = st_ok ? 0 : (m_seqerr | (m_state == 2 && bad));
      m_cnt = newcnt;
      if (st_ok) begin
        m_state = 1; m_dirclk = cfg_dirclk; m_both = cfg_both; m_inv = cfg_inv;
      end else if (cmd_stop && m_state != 2) m_state = 0;
      else if (cmd_enable && m_state == 1) m_state = 2;
      else if (cmd_disable && m_state != 0) m_state = 1;
      void'(m_h.pop_front());
      m_h.push_back({ch2, ch1});
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R12 count_o vs model", count_o, m_count);
      chk("R8 delta_o vs model", delta_o, m_delta);
      chk("R9 rd_err vs model", rd_err, m_rderr);
      chk("R10 seq_err vs model", seq_err, m_seqerr);
      chk("R6 state_o vs model", state_o, m_state);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(int c);
    case (c)
      0: cmd_start = 1;
      1: cmd_stop = 1;
      2: cmd_enable = 1;
      3: cmd_disable = 1;
      default: rd_delta = 1;
    endcase
    tick(1);
    cmd_start = 0; cmd_stop = 0; cmd_enable = 0; cmd_disable = 0; rd_delta = 0;
  endtask

  task automatic set_phase(int p);
    ph = p;
    ch1 = (p == 1 || p == 2);
    ch2 = (p == 2 || p == 3);
  endtask

  task automatic gray(int dir, int n);
    for (int i = 0; i < n; i++) begin
      set_phase((ph + dir + 4) % 4);
      tick(3);
    end
  endtask

  task automatic restart(bit dc, bit bo, bit iv);
    cfg_dirclk = dc; cfg_both = bo; cfg_inv = iv;
    cmd(0);
    cmd(2);
  endtask

  task automatic clk_toggles(int n);
    for (int i = 0; i < n; i++) begin
      ch2 = ~ch2;
      tick(3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 0; ch1 = 0; ch2 = 0; cfg_dirclk = 0; cfg_both = 0; cfg_inv = 0;
    cmd_start = 0; cmd_stop = 0; cmd_enable = 0; cmd_disable = 0;
    rd_count = 1; rd_delta = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R6 reset state", state_o, 0);
    chk("R6 reset count", count_o, 0);

    cmd(2);
    chk("R6 enable from stopped ignored", state_o, 0);
    cmd(4);
    chk("R9 delta in stopped", delta_o, 0);
    chk("R9 rd_err pulse", rd_err, 1);
    tick(1);
    chk("R9 rd_err one cycle", rd_err, 0);

    // quadrature, both edges
    restart(0, 1, 0);
    chk("R6 active", state_o, 2);
    gray(1, 8);
    chk("R1 forward two cycles", count_o, 8);
    gray(-1, 3);
    chk("R1 reverse three steps", count_o, 5);
    cmd(4);
    chk("R8 delta positive", delta_o, 5);
    cmd(4);
    chk("R8 delta zero", delta_o, 0);

    cmd(3);
    chk("R6 disable to ready", state_o, 1);
    gray(1, 2);
    chk("R7 frozen while ready", count_o, 5);

    // single edge
    restart(0, 0, 0);
    gray(1, 4);
    chk("R2 single edge cycle", count_o, 7);

    // inversion
    cmd(3);
    restart(0, 0, 1);
    gray(1, 4);
    chk("R4 inverted single edge", count_o, 5);
    cmd(3);
    restart(0, 1, 1);
    gray(1, 4);
    chk("R4 inverted both edges", count_o, 1);
    cmd(3);
    restart(0, 1, 0);
    gray(1, 4);
    chk("R1 back to 5", count_o, 5);

    // direction / clock mode
    cmd(3);
    set_phase(0); tick(3);
    restart(1, 0, 0);
    clk_toggles(4);
    chk("R3 rising clock up", count_o, 7);
    cmd(3);
    restart(1, 1, 0);
    ch1 = 1; tick(3);
    clk_toggles(4);
    chk("R3 both edges down", count_o, 3);
    cmd(3);
    restart(1, 1, 1);
    clk_toggles(2);
    chk("R4 inverted direction", count_o, 5);

    // configuration ignored while active
    cfg_dirclk = 0; cfg_inv = 0;
    cmd(0);
    chk("R11 start while active ignored", state_o, 2);
    clk_toggles(2);
    chk("R11 old configuration kept", count_o, 7);

    // illegal quadrature step
    cmd(3);
    ch1 = 0; ch2 = 0; ph = 0; tick(3);
    restart(0, 1, 0);
    ch1 = 1; ch2 = 1; tick(3);
    chk("R10 double change not counted", count_o, 7);
    chk("R10 seq_err set", seq_err, 1);
    ch1 = 0; ch2 = 0; tick(3);
    chk("R10 seq_err sticky", seq_err, 1);
    cmd(3);
    cmd(0);
    chk("R10 cleared by start", seq_err, 0);

    // clear on start from stopped, wrap, signed delta
    cmd(1);
    chk("R6 stop to stopped", state_o, 0);
    cmd(0);
    chk("R7 start from stopped clears", count_o, 0);
    cmd(2);
    gray(-1, 1);
    chk("R5 wrap down", count_o, 16'hFFFF);
    cmd(4);
    chk("R8 delta -1 across wrap", delta_o, 16'hFFFF);
    gray(1, 1);
    chk("R5 wrap up", count_o, 0);
    cmd(4);
    chk("R8 delta +1 across wrap", delta_o, 1);

    // latency and strobe behaviour
    set_phase(1);
    tick(2);
    chk("R12 not yet after two edges", count_o, 0);
    tick(1);
    chk("R12 visible after third edge", count_o, 1);
    rd_count = 0;
    gray(1, 1);
    tick(1);
    chk("R12 count_o holds without strobe", count_o, 1);
    rd_count = 1;
    tick(1);
    chk("R12 count_o after strobe", count_o, 2);

    tick(4);
    report();
  end
endmodule